// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

This block is a small synchronous counter for one digit. It steps on the rising clock edge. It can be cleared, it can load a value from a 4-bit data input, and it can hold its value. Two parameters fix its variant when it is built:

- `DECADE` selects modulo-10 counting (0 to 9) or modulo-16 counting (0 to 15).
- `ASYNC_CLR` selects whether the clear input acts at once or waits for the next rising clock edge.

Several of these counters can run from one clock and form a multi-digit counter. The lowest stage has `carry_in` tied high. Each stage's `carry_out` drives the `carry_in` of the next stage. `carry_out` is a combinational function of the current count and `carry_in`. As a result, every stage that must roll over does so on the same clock edge.

When two controls are active together, clear wins over load, and load wins over counting. Counting needs both `cnt_en` and `carry_in` to be high.

Top module: `spc_counter`

## Requirements
- R1: With `clr_n`, `load_n`, `cnt_en` and `carry_in` all high, `count` increases by one on each rising clock edge.
- R2: While `cnt_en` is low and `clr_n`, `load_n` are high, clock edges leave `count` unchanged.
- R3: While `carry_in` is low and `clr_n`, `load_n` are high, clock edges leave `count` unchanged.
- R4: With `clr_n` high and `load_n` low, the next rising edge copies `din` into `count`, whatever `cnt_en` and `carry_in` are.
- R5: With `ASYNC_CLR`=0, `count` keeps its value while `clr_n` is low between edges, and becomes 0 at the next rising edge.
- R6: With `ASYNC_CLR`=1, `count` becomes 0 as soon as `clr_n` goes low, with no clock edge.
- R7: With `clr_n` and `load_n` both low, the edge gives `count` = 0. Clear has priority over load.
- R8: A counting edge at the maximum value (9 when `DECADE`=1, 15 when `DECADE`=0) gives `count` = 0.
- R9: `carry_out` is 1 exactly when `carry_in` is 1 and `count` is at the maximum value. It follows a change of `carry_in` within the same cycle.
- R10: With `DECADE`=1, a value from 10 to 14 that was loaded steps up by one on each counting edge, and 15 steps to 0.
- R11: Two stages share a clock. The low stage's `carry_out` drives the high stage's `carry_in`, and the high stage has `cnt_en` high. After N counting edges from 0, the pair reads (N / M_low, N mod M_low), where M_low is the low stage's modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter acts on the rising edge |
| clr_n | input | 1 | Clear, active low; acts at once or at the clock edge, set by `ASYNC_CLR` |
| load_n | input | 1 | Load, active low; copies `din` at the next rising edge |
| cnt_en | input | 1 | Count enable, active high |
| carry_in | input | 1 | Carry from the previous stage, active high; also gates counting |
| din | input | 4 | Value to load |
| count | output | 4 | Current count |
| carry_out | output | 1 | High when `carry_in` is high and `count` is at the maximum value |

## Verification
Clear and load can both be requested for the same edge. The bench drives both low in one vector, while the counter holds a nonzero value and `din` holds a different nonzero value. The result must be 0, not the value on `din`. This is repeated on the asynchronous variant, with the clear held low across an edge while load is also low. The chain test also checks a case where the low stage wraps and the high stage steps on the same edge: across the 9-to-0 transitions, both digits must read correctly right after that edge.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    // Operation chosen for the coming edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } spc_op_e;

    typedef struct packed {
        cnt_t cnt;
    } spc_state_t;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
    import spc_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    cnt_en,
    input  logic    carry_in,
    output spc_op_e op
);
    // Clear wins over load, and load wins over counting.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (cnt_en && carry_in) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/spc_step.sv
module spc_step
    import spc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  cnt_t cur,
    output cnt_t inc,
    output logic at_max
);
    localparam cnt_t MAX_V = DECADE ? cnt_t'(9) : cnt_t'((1 << CNT_W) - 1);

    assign at_max = (cur == MAX_V);

    generate
        if (DECADE) begin : g_dec
            // Values above 9 keep stepping up; the width wrap returns 15 to 0.
            assign inc = at_max ? '0 : cur + cnt_t'(1);
        end else begin : g_bin
            assign inc = cur + cnt_t'(1);
        end
    endgenerate
endmodule

// File: rtl/spc_counter.sv
module spc_counter
    import spc_pkg::*;
#(
    parameter bit DECADE    = 1'b1,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             carry_in,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] count,
    output logic             carry_out
);
    localparam cnt_t MAX_V = DECADE ? cnt_t'(9) : cnt_t'((1 << CNT_W) - 1);

    spc_state_t st_d, st_q;
    spc_op_e    op;
    cnt_t       inc;
    logic       at_max;

    spc_ctrl u_ctrl (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_in (carry_in),
        .op       (op)
    );

    spc_step #(.DECADE(DECADE)) u_step (
        .cur    (st_q.cnt),
        .inc    (inc),
        .at_max (at_max)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_LOAD:  st_d.cnt = din;
            OP_STEP:  st_d.cnt = inc;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign count     = st_q.cnt;
    assign carry_out = carry_in & at_max;

    // Assertions: armed after the first clear seen at an edge.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            armed_q <= 1'b1;
        end
    end

    a_r1_step: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        (load_n && cnt_en && carry_in && count != MAX_V && count != cnt_t'((1 << CNT_W) - 1))
        |=> (count == cnt_t'($past(count) + cnt_t'(1))));

    a_r2_hold: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        (load_n && !cnt_en) |=> $stable(count));

    a_r3_hold: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        (load_n && !carry_in) |=> $stable(count));

    a_r4_load: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        !load_n |=> (count == $past(din)));

    // R8 and R9: a carry that is allowed to count must wrap the digit.
    a_r8_wrap: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        (carry_out && cnt_en && load_n) |=> (count == '0));

    generate
        if (ASYNC_CLR) begin : g_chk_async
            a_r6_async_clear: assert property (@(posedge clk) disable iff (!armed_q)
                !clr_n |-> (count == '0));
        end else begin : g_chk_sync
            a_r5_sync_clear: assert property (@(posedge clk) disable iff (!armed_q)
                !clr_n |=> (count == '0));
        end
    endgenerate
endmodule

// File: tb/tb_spc_counter.sv
module tb_spc_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    // Vector: [12]clr_n [11]load_n [10]cnt_en [9]carry_in [8:5]din [4:1]exp count [0]exp carry_out
    localparam logic [12:0] VEC [0:NV-1] = '{
        13'b0_1_1_1_0000_0000_0,  // R5 clear gives 0 at the edge
        13'b1_1_1_1_0000_0001_0,  // R1
        13'b1_1_1_1_0000_0010_0,  // R1
        13'b1_0_1_1_0111_0111_0,  // R4 load 7
        13'b1_1_1_1_0000_1000_0,  // R1
        13'b1_1_1_1_0000_1001_1,  // R9 max with carry_in
        13'b1_1_0_1_0000_1001_1,  // R2 hold, carry still high
        13'b1_1_1_0_0000_1001_0,  // R3 hold, R9 carry low
        13'b1_1_1_1_0000_0000_0,  // R8 9 wraps to 0
        13'b1_0_0_0_0011_0011_0,  // R4 load ignores enables
        13'b0_0_1_1_0101_0000_0,  // R7 clear beats load
        13'b1_0_1_1_1100_1100_0,  // R10 load 12
        13'b1_1_1_1_0000_1101_0,  // R10
        13'b1_1_1_1_0000_1110_0,  // R10
        13'b1_1_1_1_0000_1111_0,  // R10 15 is not max
        13'b1_1_1_1_0000_0000_0,  // R10 15 to 0
        13'b1_1_1_1_0000_0001_0   // R1
    };

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       a_clr_n, a_load_n, a_en, a_ci, a_co;
    logic [3:0] a_din, a_cnt;
    logic       b_clr_n, b_load_n, b_en, b_ci, b_ci_eff, b_co;
    logic [3:0] b_din, b_cnt;
    logic       chain;

    assign b_ci_eff = chain ? a_co : b_ci;

    spc_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) dut (
        .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .cnt_en(a_en),
        .carry_in(a_ci), .din(a_din), .count(a_cnt), .carry_out(a_co)
    );

    spc_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b1)) dut_b (
        .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .cnt_en(b_en),
        .carry_in(b_ci_eff), .din(b_din), .count(b_cnt), .carry_out(b_co)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        chain = 1'b0;
        a_clr_n = 1'b1; a_load_n = 1'b1; a_en = 1'b1; a_ci = 1'b1; a_din = 4'd0;
        b_clr_n = 1'b1; b_load_n = 1'b1; b_en = 1'b1; b_ci = 1'b1; b_din = 4'd0;
        #1;
        b_clr_n = 1'b0;
        #1;
        chk("R6 reset state async", int'(b_cnt), 0);
        b_clr_n = 1'b1;

        // Table walk on the decade, clock-synchronous clear stage.
        for (int i = 0; i < NV; i++) begin
            a_clr_n  = VEC[i][12];
            a_load_n = VEC[i][11];
            a_en     = VEC[i][10];
            a_ci     = VEC[i][9];
            a_din    = VEC[i][8:5];
            step();
            chk($sformatf("vec %0d count", i), int'(a_cnt), int'(VEC[i][4:1]));
            chk($sformatf("vec %0d carry", i), int'(a_co), int'(VEC[i][0]));
        end

        // R5: clear waits for the edge.
        a_en = 1'b0;
        a_clr_n = 1'b0;
        #1;
        chk("R5 count kept before edge", int'(a_cnt), 1);
        step();
        chk("R5 cleared at edge", int'(a_cnt), 0);
        a_clr_n = 1'b1;

        // Binary stage with immediate clear.
        b_load_n = 1'b0; b_din = 4'd6;
        step();
        chk("R4 binary load", int'(b_cnt), 6);
        b_load_n = 1'b1;
        step();
        chk("R1 binary step", int'(b_cnt), 7);
        b_clr_n = 1'b0;
        #1;
        chk("R6 immediate clear", int'(b_cnt), 0);
        b_load_n = 1'b0; b_din = 4'd9;
        step();
        chk("R7 clear beats load async", int'(b_cnt), 0);
        b_clr_n = 1'b1; b_din = 4'd14;
        step();
        chk("R4 binary load 14", int'(b_cnt), 14);
        chk("R9 no carry below max", int'(b_co), 0);
        b_load_n = 1'b1;
        step();
        chk("R9 binary carry at 15", int'(b_co), 1);
        step();
        chk("R8 binary wrap", int'(b_cnt), 0);

        // R11: two-stage chain.
        a_clr_n = 1'b0; b_clr_n = 1'b0; a_load_n = 1'b1; b_load_n = 1'b1;
        step();
        chk("R11 low stage cleared", int'(a_cnt), 0);
        chk("R11 high stage cleared", int'(b_cnt), 0);
        a_clr_n = 1'b1; b_clr_n = 1'b1;
        a_en = 1'b1; a_ci = 1'b1; b_en = 1'b1; chain = 1'b1;
        for (int k = 1; k <= 29; k++) begin
            step();
            chk($sformatf("R11 low digit at %0d", k), int'(a_cnt), k % 10);
            chk($sformatf("R11 high digit at %0d", k), int'(b_cnt), k / 10);
        end
        chk("R9 carry at 9", int'(a_co), 1);
        a_ci = 1'b0;
        #1;
        chk("R9 carry follows carry_in", int'(a_co), 0);
        step();
        chk("R3 low stage holds", int'(a_cnt), 9);
        chk("R11 high stage holds", int'(b_cnt), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule